// File: doc/BRIEF.md
# Two-Step Subranging Conversion Sequencer

This block is the digital half of a two-step analog-to-digital converter. A first bank of 31 comparators, fed by a resistor ladder with taps every 1/32 of full scale, gives a thermometer code. The block turns it into the five upper result bits and holds them in a register. That register also drives the coarse DAC. The amplified residue then goes to a second bank of 15 comparators. After a programmable settling delay, the same thermometer-to-binary logic turns those 15 lines into the four lower bits.

The comparator lines reach the block with inverted polarity: a low line means the input lies at or above that tap. The block complements every line before decoding. Noise can leave a gap ("bubble") in a thermometer code. The encoder ignores such gaps by taking the highest asserted tap as the code.

A conversion starts with a one-cycle `start`. A controller then steps through five states:
- `ST_IDLE`: waiting for `start`.
- `ST_SAMPLE`: the track phase, with `sample_hold` high.
- `ST_COARSE`: the coarse bank settles on the held input and the coarse register loads.
- `ST_SETTLE`: waiting for the residue.
- `ST_FINE`: the fine bits are captured.

The transitions are:
- IDLE→SAMPLE when `start` is accepted.
- SAMPLE→COARSE after `SAMPLE_CYCLES` cycles.
- COARSE→SETTLE when the captured settle count is non-zero.
- COARSE→FINE when the captured settle count is zero.
- SETTLE→FINE when the settle count expires.
- FINE→IDLE always.

At the default parameters a conversion takes a few tens of cycles. This keeps the sample period well under 1.6 µs at 100 MHz.

Top module: `subrange_adc_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `result`, `result_valid`, `coarse_code`, `busy` and `sample_hold` are all 0.
- R2: Bit i of `cmp_coarse_n` (i = 0..30) is low when the input is at or above tap (i+1)/32 of full scale. The captured `coarse_code` is the index plus one of the highest low bit, or 0 if none is low.
- R3: Bit j of `cmp_fine_n` (j = 0..14) is low when the residue is at or above fine tap j+1. The four low bits of `result` are decoded by the same rule.
- R4: `result` = {coarse code, fine code}, 9 bits with the coarse bits on top. As a result, `result[8]` is set exactly when the half-scale line (bit 15) is low. `result[7]` is set when the input lies in [1/4, 1/2) or at or above 3/4 of full scale.
- R5: A high (deasserted) line below the highest low line does not change the decoded value, in either bank.
- R6: After `start` is accepted, `sample_hold` is high for exactly `SAMPLE_CYCLES` consecutive cycles, starting the following cycle. Changes of the input after that phase do not affect the result.
- R7: `settle_cycles` is captured when `start` is accepted. The fine bits are latched after `coarse_code` has been stable for that many full cycles. `result_valid` rises `SAMPLE_CYCLES + settle_cycles + 2` clock edges after the edge that accepted `start`.
- R8: `result_valid` is a one-cycle pulse. `result` changes only together with it and holds its value until the next conversion completes.
- R9: `start` while `busy` is high is ignored: no extra result and no change in timing.
- R10: `coarse_code` is the stored coarse register, cleared asynchronously by reset. It changes only at the end of the coarse phase of a conversion and stays valid for the DAC afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion (accepted only when idle) |
| settle_cycles | input | 8 | Residue settling delay in cycles, captured at start |
| cmp_coarse_n | input | 31 | Coarse comparator lines, active low |
| cmp_fine_n | input | 15 | Fine comparator lines, active low |
| sample_hold | output | 1 | High while the sample-and-hold tracks |
| coarse_code | output | 5 | Coarse register, drives the coarse DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 9 | Last conversion result |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench models the comparator banks, the sample-and-hold and a residue path that shows a wrong fine code until `coarse_code` has been stable for the programmed delay. A design that counts the settling one cycle short therefore latches a wrong low nibble.

Inputs on tap boundaries (0, 16, 255, 256, 511) expose off-by-one tap decoding and a dropped complement. Injected bubbles catch an encoder that counts lines instead of taking the highest one. A second `start` during a conversion catches a restart as a changed latency or an extra result. Changing the analog input right after the sample phase exposes a design that tracks for too long.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_COARSE,
        ST_SETTLE,
        ST_FINE
    } conv_state_t;
endpackage

// File: rtl/therm_enc.sv
// Thermometer-to-binary encoder: highest asserted tap wins (bubble tolerant).
module therm_enc #(
    parameter int BITS     = 5,
    parameter bit INVERTED = 1'b1,
    localparam int LEVELS  = (1 << BITS) - 1
) (
    input  logic [LEVELS-1:0] raw,
    output logic [BITS-1:0]   code
);
    logic [LEVELS-1:0] lines;

    generate
        if (INVERTED) begin : g_inv
            assign lines = ~raw;
        end else begin : g_true
            assign lines = raw;
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lines[i]) code = BITS'(i + 1);
        end
    end
endmodule

// File: rtl/coarse_reg.sv
// Coarse result register; asynchronous clear overrides clock and data.
module coarse_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/subrange_fsm.sv
module subrange_fsm
    import subrange_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 2,
    parameter int SETTLE_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                sample_hold,
    output logic                busy,
    output logic                load_coarse,
    output logic                load_fine
);
    localparam logic [SETTLE_W-1:0] SAMPLE_LOAD = SETTLE_W'(SAMPLE_CYCLES - 1);

    conv_state_t         state;
    logic [SETTLE_W-1:0] cnt;
    logic [SETTLE_W-1:0] settle_q;

    // State register with counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            settle_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SAMPLE;
                        cnt      <= SAMPLE_LOAD;
                        settle_q <= settle_cycles;
                    end
                end
                ST_SAMPLE: begin
                    if (cnt == '0) state <= ST_COARSE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_COARSE: begin
                    if (settle_q == '0) begin
                        state <= ST_FINE;
                    end else begin
                        state <= ST_SETTLE;
                        cnt   <= settle_q - 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == '0) state <= ST_FINE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_FINE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        sample_hold = 1'b0;
        busy        = 1'b1;
        load_coarse = 1'b0;
        load_fine   = 1'b0;
        unique case (state)
            ST_IDLE:   busy        = 1'b0;
            ST_SAMPLE: sample_hold = 1'b1;
            ST_COARSE: load_coarse = 1'b1;
            ST_SETTLE: ;
            ST_FINE:   load_fine   = 1'b1;
            default:   busy        = 1'b0;
        endcase
    end
endmodule

// File: rtl/subrange_adc_ctrl.sv
module subrange_adc_ctrl #(
    parameter int COARSE_BITS   = 5,
    parameter int FINE_BITS     = 4,
    parameter int SAMPLE_CYCLES = 2,
    parameter int SETTLE_W      = 8,
    localparam int COARSE_LVLS  = (1 << COARSE_BITS) - 1,
    localparam int FINE_LVLS    = (1 << FINE_BITS) - 1,
    localparam int RES_W        = COARSE_BITS + FINE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SETTLE_W-1:0]    settle_cycles,
    input  logic [COARSE_LVLS-1:0] cmp_coarse_n,
    input  logic [FINE_LVLS-1:0]   cmp_fine_n,
    output logic                   sample_hold,
    output logic [COARSE_BITS-1:0] coarse_code,
    output logic                   busy,
    output logic [RES_W-1:0]       result,
    output logic                   result_valid
);
    logic                   load_coarse;
    logic                   load_fine;
    logic [COARSE_BITS-1:0] coarse_dec;
    logic [FINE_BITS-1:0]   fine_dec;

    subrange_fsm #(
        .SAMPLE_CYCLES (SAMPLE_CYCLES),
        .SETTLE_W      (SETTLE_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .settle_cycles (settle_cycles),
        .sample_hold   (sample_hold),
        .busy          (busy),
        .load_coarse   (load_coarse),
        .load_fine     (load_fine)
    );

    therm_enc #(.BITS(COARSE_BITS), .INVERTED(1'b1)) u_coarse_enc (
        .raw  (cmp_coarse_n),
        .code (coarse_dec)
    );

    therm_enc #(.BITS(FINE_BITS), .INVERTED(1'b1)) u_fine_enc (
        .raw  (cmp_fine_n),
        .code (fine_dec)
    );

    coarse_reg #(.W(COARSE_BITS)) u_coarse_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_coarse),
        .d     (coarse_dec),
        .q     (coarse_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= load_fine;
            if (load_fine) result <= {coarse_code, fine_dec};
        end
    end
endmodule

// File: rtl/subrange_adc_ctrl_chk.sv
module subrange_adc_ctrl_chk #(
    parameter int CW = 5,
    parameter int RW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          sample_hold,
    input logic          busy,
    input logic [CW-1:0] coarse_code,
    input logic [RW-1:0] result,
    input logic          result_valid
);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> result_valid);

    // R9
    sample_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_hold) |-> (!$past(busy) && $past(start)));

    // R10
    coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coarse_code) |-> ($past(busy) && !$past(sample_hold)));

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (!busy && $past(busy)));
endmodule

bind subrange_adc_ctrl subrange_adc_ctrl_chk #(.CW(COARSE_BITS), .RW(RES_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .sample_hold  (sample_hold),
    .busy         (busy),
    .coarse_code  (coarse_code),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/tb_subrange_adc_ctrl.sv
`timescale 1ns/1ps
module tb_subrange_adc_ctrl;
    localparam int SC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  settle_cycles = '0;
    logic [30:0] cmp_coarse_n;
    logic [14:0] cmp_fine_n;
    logic        sample_hold;
    logic [4:0]  coarse_code;
    logic        busy;
    logic [8:0]  result;
    logic        result_valid;

    always #5 clk = ~clk;

    subrange_adc_ctrl #(.SAMPLE_CYCLES(SC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .cmp_coarse_n(cmp_coarse_n), .cmp_fine_n(cmp_fine_n),
        .sample_hold(sample_hold), .coarse_code(coarse_code), .busy(busy),
        .result(result), .result_valid(result_valid)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;

    // analog model
    int analog = 0;
    int held = 0;
    int stable_cnt = 0;
    int settle_req = 0;
    logic [4:0] last_coarse = '0;
    bit bubble_en = 0;

    typedef struct { int v; int start_cyc; int s; } exp_t;
    exp_t q[$];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // comparator banks (inverted polarity)
    always_comb begin
        int t;
        int r;
        t = held / 16;
        for (int i = 0; i < 31; i++) cmp_coarse_n[i] = !(held >= (i + 1) * 16);
        if (bubble_en && t >= 2) cmp_coarse_n[t-2] = 1'b1;
        r = held - int'(coarse_code) * 16;
        for (int j = 0; j < 15; j++) begin
            if (stable_cnt < settle_req) cmp_fine_n[j] = 1'b0;
            else                         cmp_fine_n[j] = !(r >= j + 1);
        end
        if (bubble_en && stable_cnt >= settle_req && r >= 3) cmp_fine_n[r-3] = 1'b1;
    end

    // sample-and-hold and residue settling model
    always @(negedge clk) begin
        if (sample_hold) held = analog;
        if (coarse_code != last_coarse) stable_cnt = 0;
        else if (stable_cnt < 1000) stable_cnt++;
        last_coarse = coarse_code;
    end

    // sample phase width monitor (R6)
    int sh_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_hold) sh_len++;
            else if (sh_len != 0) begin
                chk("R6 sample width", sh_len, SC);
                sh_len = 0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            if (q.size() == 0) begin
                chk("R9 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R2/R3 result", int'(result), e.v);
                chk("R4 top bit", int'(result[8]), int'(e.v >= 256));
                chk("R4 second bit", int'(result[7]),
                    int'((e.v >= 128 && e.v < 256) || e.v >= 384));
                chk("R7 latency", cyc - e.start_cyc, SC + e.s + 2);
                chk("R10 coarse_code", int'(coarse_code), e.v / 16);
            end
            done_cnt++;
        end
    end

    task automatic convert(input int v, input int s, input bit bub, input bit mid);
        int target;
        exp_t e;
        target = done_cnt + 1;
        @(negedge clk);
        analog = v;
        settle_cycles = 8'(s);
        settle_req = s;
        bubble_en = bub;
        start = 1'b1;
        e.v = v; e.start_cyc = cyc + 1; e.s = s;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (mid) begin
            repeat (2) @(negedge clk);
            start = 1'b1;              // R9: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (sample_hold) @(negedge clk);
        analog = 511 - v;              // R6: held value must be used
        for (int k = 0; k < 400 && done_cnt < target; k++) @(negedge clk);
        if (done_cnt < target) chk("R7 conversion timeout", done_cnt, target);
        repeat (2) @(negedge clk);
        chk("R8 valid pulse low", int'(result_valid), 0);
        chk("R8 result held", int'(result), v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 result", int'(result), 0);
        chk("R1 valid", int'(result_valid), 0);
        chk("R1 coarse", int'(coarse_code), 0);
        chk("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sample_hold", int'(sample_hold), 0);
        chk("R1 busy after release", int'(busy), 0);

        convert(0,   3, 0, 0);   // R2 R3 lowest code
        convert(511, 3, 0, 0);   // R2 R3 highest code
        convert(16,  0, 0, 0);   // R7 zero settle, tap boundary
        convert(255, 1, 0, 0);   // R4 just below half scale
        convert(256, 5, 0, 0);   // R4 half scale
        convert(130, 7, 0, 0);   // R4 second-bit band
        convert(400, 2, 0, 0);   // R4 above 3/4
        convert(383, 4, 1, 0);   // R5 bubbles in both banks
        convert(77,  6, 1, 0);   // R5
        convert(300, 3, 0, 1);   // R9 start while busy
        convert(45,  0, 0, 1);   // R9 with zero settle
        for (int n = 0; n < 6; n++) convert((n * 97 + 31) % 512, n, n[0], 0);

        repeat (5) @(negedge clk);
        chk("R9 no pending results", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule